// File: doc/BRIEF.md
# Linear Burst Bus Master Sequencer

This block is the bus-master cycle engine for a 32-bit local bus. Software-side logic hands it a run: a starting word address, a word count, a burst-size code and two limits. The block requests the bus and waits for the grant. It then issues address strobes and steps the word address by one for each transfer. It reads the target's burst-ready and plain-ready responses, and it drives a last-transfer line that tells the target whether the engine wants to keep bursting.

A linear burst is used only when the burst-size code is legal and the start address sits on a boundary of the burst's size. Otherwise every word moves as a single access with the last-transfer line high. A plain-ready response during a burst drops the engine into two-cycle accesses, each with its own strobe, and the last-transfer line stays low. A later burst-ready response that comes without plain ready picks up the burst again. The run ends early when the data runs out, the transfer budget runs out or the bus-occupancy timer runs out. The engine then marks the final transfer and lets go of the bus.

Top module: `lbs_seq`

## Requirements
- R1: A burst-size code other than 1, 2 or 4 makes every transfer a single access: a strobe before each word and the last-transfer line high in every data phase.
- R2: Bursting is used only if the start word address has its low log2(4×code) bits at zero (byte address mod 16×code is zero). An unaligned start gives single accesses as in R1.
- R3: Codes 1, 2 and 4 give bursts of 4, 8 and 16 words. The last-transfer line is high in the data phase of the final word of each burst, and a longer run starts a new burst with a new strobe.
- R4: The word address rises by one on every completed transfer. Within a burst, the address bits above the burst's word-index field do not change.
- R5: The address strobe is high for exactly one clock before the first data phase of each access sequence. A burst continued by burst ready has no strobe between its words.
- R6: Plain ready during a burst, when the last-transfer line is low, ends that access. The next word then gets a fresh strobe, and the last-transfer line stays low.
- R7: After R6, a burst-ready response without plain ready lets the following word continue with no strobe.
- R8: If plain ready and burst ready are high together, plain ready wins and the access is treated as in R6.
- R9: When the current word is the last of the run's count, or the data-last input is high in its data phase, that word carries the last-transfer line and the bus is then released.
- R10: A transfer budget is loaded at grant and counts completed words. The word that uses up the budget carries the last-transfer line and ends the run.
- R11: A bus-occupancy timer is loaded at grant and counts down once per clock in the address and data phases. A data phase seen with the timer at zero carries the last-transfer line and ends the run.
- R12: After reset the bus request, strobe, last-transfer and done outputs are low.
- R13: The bus request is high from the clock after a start until the run ends. The done pulse lasts one clock, and bus request is low during it. No strobe appears before the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | Pulse that starts a run (ignored while busy or when word count is zero) |
| run_waddr | input | 30 | Start word address (byte address bits 31:2) |
| run_words | input | CNT_W | Number of words in the run |
| burst_code | input | 3 | Burst-size code; 1, 2, 4 legal |
| cyc_budget | input | CYC_W | Transfer budget loaded at grant |
| occ_limit | input | BAT_W | Bus-occupancy timer load value |
| data_last | input | 1 | Current word is the last available from the data source |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| adr_strobe | output | 1 | Address strobe, one clock per access sequence |
| bus_addr | output | 30 | Word address (byte bits 31:2) |
| burst_rdy | input | 1 | Target burst-ready response |
| plain_rdy | input | 1 | Target plain-ready response |
| last_xfer | output | 1 | Last-transfer indicator, valid in data phases |
| run_done | output | 1 | One-clock pulse when the bus is released |

## Verification
The collisions that matter happen inside one data phase. A burst-boundary end, a run-ending limit and a target response can all land in the same cycle, and so can both ready responses. The bench builds each case from vectors. Both readies are raised on a mid-burst word. Plain ready is given on the word before a block boundary. The budget, the occupancy timer or the data-last input is set to expire on a word inside a burst. Each case is judged by the counts of strobes, last-transfer marks and words moved, and by the exact sequence of word addresses.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    localparam int WA_W  = 30;
    localparam int IDX_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_DATA,
        ST_DONE
    } lbs_state_e;

    typedef struct packed {
        logic plain;
        logic burst;
    } lbs_resp_t;

    function automatic logic code_legal(input logic [2:0] code);
        return (code == 3'd1) || (code == 3'd2) || (code == 3'd4);
    endfunction

    // word-index field mask for a legal code; zero for reserved codes
    function automatic logic [IDX_W-1:0] idx_mask(input logic [2:0] code);
        logic [IDX_W-1:0] m;
        case (code)
            3'd1:    m = 4'b0011;
            3'd2:    m = 4'b0111;
            3'd4:    m = 4'b1111;
            default: m = 4'b0000;
        endcase
        return m;
    endfunction

    function automatic logic start_aligned(input logic [WA_W-1:0] wa,
                                           input logic [2:0] code);
        return (wa[IDX_W-1:0] & idx_mask(code)) == '0;
    endfunction

endpackage

// File: rtl/lbs_addr.sv
module lbs_addr
    import lbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WA_W-1:0]  load_addr,
    input  logic [2:0]       load_code,
    input  logic             adv,
    output logic [WA_W-1:0]  addr,
    output logic [IDX_W-1:0] mask,
    output logic             blk_end
);
    logic [WA_W-1:0]  addr_q;
    logic [IDX_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            mask_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            mask_q <= idx_mask(load_code);
        end else if (adv) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr    = addr_q;
    assign mask    = mask_q;
    assign blk_end = (addr_q[IDX_W-1:0] & mask_q) == mask_q;

    // R4
    upper_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !blk_end && !load) |=>
        ((addr_q & ~{{(WA_W-IDX_W){1'b0}}, mask_q}) ==
         ($past(addr_q) & ~{{(WA_W-IDX_W){1'b0}}, mask_q})));

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |=> (addr_q == $past(addr_q) + 1'b1));

endmodule

// File: rtl/lbs_limits.sv
module lbs_limits #(
    parameter int CNT_W = 8,
    parameter int CYC_W = 8,
    parameter int BAT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_load,
    input  logic [CNT_W-1:0] words_in,
    input  logic             gnt_load,
    input  logic [CYC_W-1:0] cyc_in,
    input  logic [BAT_W-1:0] bat_in,
    input  logic             on_bus,
    input  logic             beat,
    input  logic             data_last,
    output logic             stop
);
    logic [CNT_W-1:0] rem_q;
    logic [CYC_W-1:0] cyc_q;
    logic [BAT_W-1:0] bat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (run_load) begin
            rem_q <= words_in;
        end else if (beat && rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
            bat_q <= '0;
        end else if (gnt_load) begin
            cyc_q <= cyc_in;
            bat_q <= bat_in;
        end else begin
            if (beat && cyc_q != '0) cyc_q <= cyc_q - 1'b1;
            if (on_bus && bat_q != '0) bat_q <= bat_q - 1'b1;
        end
    end

    logic words_end, cyc_end, bat_end;
    assign words_end = (rem_q == CNT_W'(1));
    assign cyc_end   = (cyc_q <= CYC_W'(1));
    assign bat_end   = (bat_q == '0);
    assign stop      = words_end || data_last || cyc_end || bat_end;

    // R9
    no_underrun_chk: assert property (@(posedge clk) disable iff (rst)
        beat |-> (rem_q != '0));

endmodule

// File: rtl/lbs_ctrl.sv
module lbs_ctrl
    import lbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       burst_ok,
    input  logic       bus_gnt,
    input  lbs_resp_t  resp,
    input  logic       blk_end,
    input  logic       stop,
    output lbs_state_e state,
    output logic       run_load,
    output logic       gnt_load,
    output logic       beat,
    output logic       on_bus,
    output logic       ads,
    output logic       blast,
    output logic       req,
    output logic       done
);
    lbs_state_e st_q, st_d;
    logic       bm_q;

    assign beat  = (st_q == ST_DATA) && (resp.plain || resp.burst);
    assign blast = (st_q == ST_DATA) && (!bm_q || blk_end || stop);

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (start) st_d = ST_REQ;
            ST_REQ:  if (bus_gnt) st_d = ST_ADDR;
            ST_ADDR: st_d = ST_DATA;
            ST_DATA: begin
                if (beat) begin
                    if (blast && stop)  st_d = ST_DONE;
                    else if (blast)     st_d = ST_ADDR;
                    else if (resp.plain) st_d = ST_ADDR;
                    else                st_d = ST_DATA;
                end
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            bm_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && start) bm_q <= burst_ok;
        end
    end

    assign state    = st_q;
    assign run_load = (st_q == ST_IDLE) && start;
    assign gnt_load = (st_q == ST_REQ) && bus_gnt;
    assign on_bus   = (st_q == ST_ADDR) || (st_q == ST_DATA);
    assign ads      = (st_q == ST_ADDR);
    assign req      = (st_q == ST_REQ) || on_bus;
    assign done     = (st_q == ST_DONE);

    // R5
    strobe_once_chk: assert property (@(posedge clk) disable iff (rst)
        ads |=> (!ads && st_q == ST_DATA));

    // R7
    burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (beat && !resp.plain && !blast) |=> !ads);

endmodule

// File: rtl/lbs_seq.sv
module lbs_seq
    import lbs_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int CYC_W = 8,
    parameter int BAT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_start,
    input  logic [29:0]      run_waddr,
    input  logic [CNT_W-1:0] run_words,
    input  logic [2:0]       burst_code,
    input  logic [CYC_W-1:0] cyc_budget,
    input  logic [BAT_W-1:0] occ_limit,
    input  logic             data_last,
    output logic             bus_req,
    input  logic             bus_gnt,
    output logic             adr_strobe,
    output logic [29:0]      bus_addr,
    input  logic             burst_rdy,
    input  logic             plain_rdy,
    output logic             last_xfer,
    output logic             run_done
);
    lbs_state_e       state;
    lbs_resp_t        resp;
    logic             start_ok, burst_ok;
    logic             run_load, gnt_load, beat, on_bus;
    logic             blk_end, stop;
    logic [IDX_W-1:0] mask;

    assign resp.plain = plain_rdy;
    assign resp.burst = burst_rdy;
    assign start_ok   = run_start && (run_words != '0);
    assign burst_ok   = code_legal(burst_code) && start_aligned(run_waddr, burst_code);

    lbs_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start_ok),
        .burst_ok (burst_ok),
        .bus_gnt  (bus_gnt),
        .resp     (resp),
        .blk_end  (blk_end),
        .stop     (stop),
        .state    (state),
        .run_load (run_load),
        .gnt_load (gnt_load),
        .beat     (beat),
        .on_bus   (on_bus),
        .ads      (adr_strobe),
        .blast    (last_xfer),
        .req      (bus_req),
        .done     (run_done)
    );

    lbs_addr u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (run_load),
        .load_addr (run_waddr),
        .load_code (burst_code),
        .adv       (beat),
        .addr      (bus_addr),
        .mask      (mask),
        .blk_end   (blk_end)
    );

    lbs_limits #(
        .CNT_W (CNT_W),
        .CYC_W (CYC_W),
        .BAT_W (BAT_W)
    ) u_limits (
        .clk       (clk),
        .rst       (rst),
        .run_load  (run_load),
        .words_in  (run_words),
        .gnt_load  (gnt_load),
        .cyc_in    (cyc_budget),
        .bat_in    (occ_limit),
        .on_bus    (on_bus),
        .beat      (beat),
        .data_last (data_last),
        .stop      (stop)
    );

    // R1
    reserved_single_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && mask == '0) |-> last_xfer);

    // R6
    fallback_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && plain_rdy && !last_xfer) |=> adr_strobe);

    // R9
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && last_xfer && stop && (plain_rdy || burst_rdy))
        |=> (run_done && !bus_req));

    // R13
    done_free_chk: assert property (@(posedge clk) disable iff (rst)
        run_done |-> (!bus_req && !adr_strobe));

endmodule

// File: tb/test_lbs_seq.sv
module test_lbs_seq;
    localparam int PERIOD = 10;

    typedef struct packed {
        logic [29:0] wa;
        logic [7:0]  n;
        logic [2:0]  code;
        logic [15:0] pmask;   // plain ready only on word k
        logic [15:0] bmask;   // both readies on word k
        logic [7:0]  cyc;
        logic [11:0] bat;
        logic [7:0]  fidx;    // word index with data_last high, FF = none
        logic [7:0]  ew;
        logic [7:0]  ea;
        logic [7:0]  eb;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VT [NV] = '{
        // R3 R5: one 4-word burst
        '{30'd0, 8'd4, 3'd1, 16'h0, 16'h0, 8'd100, 12'd1000, 8'hFF, 8'd4, 8'd1, 8'd1, 8'd3},
        // R3: two 4-word bursts
        '{30'd0, 8'd8, 3'd1, 16'h0, 16'h0, 8'd100, 12'd1000, 8'hFF, 8'd8, 8'd2, 8'd2, 8'd3},
        // R2 R4: code 2 at byte 0x20
        '{30'd8, 8'd8, 3'd2, 16'h0, 16'h0, 8'd100, 12'd1000, 8'hFF, 8'd8, 8'd1, 8'd1, 8'd2},
        // R2: code 4 at byte 0x20 unaligned
        '{30'd8, 8'd4, 3'd4, 16'h0, 16'h0, 8'd100, 12'd1000, 8'hFF, 8'd4, 8'd4, 8'd4, 8'd2},
        // R1: reserved code 3
        '{30'd0, 8'd3, 3'd3, 16'h0, 16'h0, 8'd100, 12'd1000, 8'hFF, 8'd3, 8'd3, 8'd3, 8'd1},
        // R6 R7: plain on word 1 then resume
        '{30'd4, 8'd4, 3'd1, 16'h2, 16'h0, 8'd100, 12'd1000, 8'hFF, 8'd4, 8'd2, 8'd1, 8'd6},
        // R9: data_last on word 2
        '{30'd0, 8'd8, 3'd1, 16'h0, 16'h0, 8'd100, 12'd1000, 8'd2, 8'd3, 8'd1, 8'd1, 8'd9},
        // R10: budget of 2
        '{30'd0, 8'd8, 3'd2, 16'h0, 16'h0, 8'd2, 12'd1000, 8'hFF, 8'd2, 8'd1, 8'd1, 8'd10},
        // R11: occupancy timer of 3
        '{30'd0, 8'd8, 3'd1, 16'h0, 16'h0, 8'd100, 12'd3, 8'hFF, 8'd3, 8'd1, 8'd1, 8'd11},
        // R8: both readies on word 0
        '{30'd0, 8'd4, 3'd1, 16'h0, 16'h1, 8'd100, 12'd1000, 8'hFF, 8'd4, 8'd2, 8'd1, 8'd8},
        // R2: code 2 at byte 0x10 unaligned
        '{30'd4, 8'd2, 3'd2, 16'h0, 16'h0, 8'd100, 12'd1000, 8'hFF, 8'd2, 8'd2, 8'd2, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        run_start;
    logic [29:0] run_waddr;
    logic [7:0]  run_words;
    logic [2:0]  burst_code;
    logic [7:0]  cyc_budget;
    logic [11:0] occ_limit;
    logic        data_last;
    logic        bus_req;
    logic        bus_gnt;
    logic        adr_strobe;
    logic [29:0] bus_addr;
    logic        burst_rdy;
    logic        plain_rdy;
    logic        last_xfer;
    logic        run_done;

    int total = 0;
    int bad   = 0;

    always #(PERIOD/2) clk = ~clk;

    lbs_seq i_lbs_seq (
        .clk        (clk),
        .rst        (rst),
        .run_start  (run_start),
        .run_waddr  (run_waddr),
        .run_words  (run_words),
        .burst_code (burst_code),
        .cyc_budget (cyc_budget),
        .occ_limit  (occ_limit),
        .data_last  (data_last),
        .bus_req    (bus_req),
        .bus_gnt    (bus_gnt),
        .adr_strobe (adr_strobe),
        .bus_addr   (bus_addr),
        .burst_rdy  (burst_rdy),
        .plain_rdy  (plain_rdy),
        .last_xfer  (last_xfer),
        .run_done   (run_done)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int  words = 0, ads = 0, blasts = 0, addr_err = 0, cyc = 0;
        bit  in_data, p_ads = 0, p_data = 0, p_plain = 0, p_blast = 0, fin = 0;
        bit  pl, both;
        @(negedge clk);
        run_waddr  = v.wa;
        run_words  = v.n;
        burst_code = v.code;
        cyc_budget = v.cyc;
        occ_limit  = v.bat;
        run_start  = 1'b1;
        @(negedge clk);
        run_start  = 1'b0;
        while (!fin && cyc < 300) begin
            in_data = p_ads || (p_data && !p_plain && !p_blast);
            bus_gnt = bus_req;
            pl = 0;
            if (in_data) begin
                pl   = v.pmask[words[3:0]];
                both = v.bmask[words[3:0]];
                plain_rdy = pl || both;
                burst_rdy = !pl;
                data_last = (words == int'(v.fidx));
                pl = pl || both;
            end else begin
                plain_rdy = 1'b0;
                burst_rdy = 1'b0;
                data_last = 1'b0;
            end
            #1;
            if (in_data) begin
                if (bus_addr != v.wa + 30'(words)) addr_err++;
                if (last_xfer) blasts++;
                words++;
            end
            if (adr_strobe) ads++;
            if (run_done) begin
                fin = 1;
                if (bus_req) addr_err++;
            end
            p_ads = adr_strobe;
            p_data = in_data;
            p_plain = pl;
            p_blast = last_xfer;
            cyc++;
            @(negedge clk);
        end
        plain_rdy = 1'b0;
        burst_rdy = 1'b0;
        data_last = 1'b0;
        bus_gnt   = 1'b0;
        check($sformatf("R%0d vec%0d done", v.rq, idx), int'(fin), 1);
        check($sformatf("R%0d vec%0d words", v.rq, idx), words, int'(v.ew));
        check($sformatf("R%0d vec%0d strobes", v.rq, idx), ads, int'(v.ea));
        check($sformatf("R%0d vec%0d last_xfer", v.rq, idx), blasts, int'(v.eb));
        check($sformatf("R4 vec%0d address/release errors", idx), addr_err, 0);
    endtask

    initial begin
        rst = 1'b1;
        run_start = 0; run_waddr = 0; run_words = 0; burst_code = 0;
        cyc_budget = 0; occ_limit = 0; data_last = 0; bus_gnt = 0;
        burst_rdy = 0; plain_rdy = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        check("R12 bus_req", int'(bus_req), 0);
        check("R12 adr_strobe", int'(adr_strobe), 0);
        check("R12 last_xfer", int'(last_xfer), 0);
        check("R12 run_done", int'(run_done), 0);
        rst = 1'b0;

        // R13: request held, no strobe before grant
        begin
            int stb = 0, req_lo = 0;
            @(negedge clk);
            run_waddr = 0; run_words = 8'd1; burst_code = 3'd1;
            cyc_budget = 8'd10; occ_limit = 12'd100;
            run_start = 1'b1;
            @(negedge clk);
            run_start = 1'b0;
            for (int i = 0; i < 6; i++) begin
                if (adr_strobe) stb++;
                if (!bus_req) req_lo++;
                @(negedge clk);
            end
            check("R13 no strobe without grant", stb, 0);
            check("R13 request held", req_lo, 0);
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
        end

        for (int k = 0; k < NV; k++) run_vec(VT[k], k);

        // R13: zero-length start ignored
        begin
            int req_seen = 0;
            @(negedge clk);
            run_words = 8'd0;
            run_start = 1'b1;
            @(negedge clk);
            run_start = 1'b0;
            for (int i = 0; i < 4; i++) begin
                if (bus_req) req_seen++;
                @(negedge clk);
            end
            check("R13 zero-length run ignored", req_seen, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule